// File: doc/BRIEF.md
# Four-Bit Opcode-Driven ALU Datapath

This block is a small registered arithmetic datapath. On each rising clock edge it loads two 4-bit operands into a pair of source registers and a 4-bit instruction code into an instruction register. The stored code is decoded into one of three operations, and the decoded operation drives a one-hot activity indicator.

The operations are a ripple-carry sum of both operands, a bitwise AND of both operands, and the bitwise complement of the first operand. On the next edge the result of the decoded operation is written into a destination register. At the same time a carry flag and three condition flags are written: negative, zero and positive, with the result read as 4-bit two's complement.

The register stages overlap. While one instruction's result is being written to the destination register, the next instruction's operands and code are being loaded. A new operation can therefore be issued on every clock. An unrecognised code changes nothing in the destination register or the flags.

Top module: `alu4_datapath`

## Requirements
- R1: While `rst_n` is low at a rising edge, that edge clears the source registers, the instruction register, the destination register and all four flags to 0. The reset is synchronous and active-low.
- R2: At each rising edge with `rst_n` high, `sr1_o`, `sr2_o` and `ir_o` load `opnd_a_i`, `opnd_b_i` and `opcode_i`.
- R3: When `ir_o` holds 4'b0001 (sum), the next edge writes `(sr1_o + sr2_o) mod 16` to `dr_o` and the carry out of bit 3 to `carry_o`.
- R4: When `ir_o` holds 4'b0101 (AND), the next edge writes `sr1_o & sr2_o` to `dr_o` and clears `carry_o`.
- R5: When `ir_o` holds 4'b1001 (complement), the next edge writes `~sr1_o` to `dr_o` and clears `carry_o`. The value of `sr2_o` has no effect on this result.
- R6: For any other value of `ir_o`, the next edge leaves `dr_o`, `carry_o`, `neg_o`, `zero_o` and `pos_o` unchanged.
- R7: The flags are written on the same edge as `dr_o`. `neg_o` equals result bit 3, `zero_o` is set when the result is 0, and `pos_o` is set when the result is neither negative nor zero. After any valid operation exactly one of the three is high.
- R8: `op_busy_o` is decoded from `ir_o` without a register. Bit 0 marks the sum, bit 1 the AND and bit 2 the complement. It is all zeros for any other code and never has more than one bit set.
- R9: Back-to-back issue works: at the edge that writes one instruction's result to `dr_o`, the next instruction's operands and code load into the source and instruction registers, and neither disturbs the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opnd_a_i | input | 4 | First operand |
| opnd_b_i | input | 4 | Second operand |
| opcode_i | input | 4 | Instruction code |
| sr1_o | output | 4 | First source register |
| sr2_o | output | 4 | Second source register |
| ir_o | output | 4 | Instruction register |
| dr_o | output | 4 | Destination register |
| op_busy_o | output | 3 | One-hot active operation: bit0 sum, bit1 AND, bit2 complement |
| carry_o | output | 1 | Carry out of the last sum, 0 after AND or complement |
| neg_o | output | 1 | Result negative |
| zero_o | output | 1 | Result zero |
| pos_o | output | 1 | Result positive |

## Verification
Two things share one clock edge: the write of the destination register and flags for the instruction already held in the instruction register, and the load of the next operands and code. The bench issues a sum that produces a carry and, on the very next clock, an AND with different operands. After that edge it checks that the source and instruction registers hold the AND while the destination register and flags still show the sum. One edge later it checks the AND result. A further sequence places unrecognised codes right after a carrying sum, to confirm that the destination register and all four flags hold their values.

// File: rtl/alu4_pkg.sv
// Package alu4_pkg
// Shared instruction encodings and one-hot select positions for the ALU datapath.
// Assumes a 4-bit instruction code; any code not listed here is treated as a no-op.
package alu4_pkg;

    localparam int OPC_W = 4;

    typedef enum logic [OPC_W-1:0] {
        OPC_ADD = 4'b0001,
        OPC_AND = 4'b0101,
        OPC_NOT = 4'b1001
    } opc_e;

    localparam int SEL_ADD = 0;
    localparam int SEL_AND = 1;
    localparam int SEL_NOT = 2;
    localparam int SEL_W   = 3;

endpackage

// File: rtl/alu4_decode.sv
// Module alu4_decode
// Turns the stored instruction code into a one-hot operation select.
// Assumes codes outside the package list must yield an all-zero select.
module alu4_decode
    import alu4_pkg::*;
(
    input  logic [OPC_W-1:0] code_i,
    output logic [SEL_W-1:0] sel_o
);

    // Map each known code to its select bit; unknown codes select nothing.
    always_comb begin
        sel_o = '0;
        case (code_i)
            OPC_ADD: sel_o[SEL_ADD] = 1'b1;
            OPC_AND: sel_o[SEL_AND] = 1'b1;
            OPC_NOT: sel_o[SEL_NOT] = 1'b1;
            default: sel_o = '0;
        endcase
    end

endmodule

// File: rtl/alu4_ripple_adder.sv
// Module alu4_ripple_adder
// Parameterised adder built as a chain of one-bit full adders.
// Assumes WIDTH >= 1; carry propagates serially from bit 0 upward.
module alu4_ripple_adder #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);

    logic [WIDTH:0] chain;

    assign chain[0] = cin_i;

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_fa
            // One full-adder cell: sum bit and carry to the next stage.
            assign sum_o[gi]    = a_i[gi] ^ b_i[gi] ^ chain[gi];
            assign chain[gi+1]  = (a_i[gi] & b_i[gi]) |
                                  (a_i[gi] & chain[gi]) |
                                  (b_i[gi] & chain[gi]);
        end
    endgenerate

    assign cout_o = chain[WIDTH];

endmodule

// File: rtl/alu4_core.sv
// Module alu4_core
// Combinational operation unit: sum, AND, or complement of the first operand.
// Assumes sel_i is one-hot or zero; carry is meaningful only for the sum.
module alu4_core
    import alu4_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic [WIDTH-1:0] res_o,
    output logic             carry_o
);

    logic [WIDTH-1:0] sum_w;
    logic             cout_w;

    alu4_ripple_adder #(.WIDTH(WIDTH)) u_add (
        .a_i    (a_i),
        .b_i    (b_i),
        .cin_i  (1'b0),
        .sum_o  (sum_w),
        .cout_o (cout_w)
    );

    // Pick the result of the selected operation; carry only on a sum.
    always_comb begin
        res_o   = '0;
        carry_o = 1'b0;
        if (sel_i[SEL_ADD]) begin
            res_o   = sum_w;
            carry_o = cout_w;
        end else if (sel_i[SEL_AND]) begin
            res_o = a_i & b_i;
        end else if (sel_i[SEL_NOT]) begin
            res_o = ~a_i;
        end
    end

endmodule

// File: rtl/alu4_datapath.sv
// Module alu4_datapath
// Registered ALU datapath: source and instruction registers feed the core,
// whose result and flags are stored in the destination stage one edge later.
// Assumes synchronous active-low reset; unknown codes leave the result stage alone.
module alu4_datapath
    import alu4_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] opnd_a_i,
    input  logic [WIDTH-1:0] opnd_b_i,
    input  logic [OPC_W-1:0] opcode_i,
    output logic [WIDTH-1:0] sr1_o,
    output logic [WIDTH-1:0] sr2_o,
    output logic [OPC_W-1:0] ir_o,
    output logic [WIDTH-1:0] dr_o,
    output logic [SEL_W-1:0] op_busy_o,
    output logic             carry_o,
    output logic             neg_o,
    output logic             zero_o,
    output logic             pos_o
);

    localparam int MSB = WIDTH - 1;

    logic [SEL_W-1:0] sel_w;
    logic [WIDTH-1:0] res_w;
    logic             cy_w;
    logic             valid_w;

    // Source and instruction stage: load inputs every edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr1_o <= '0;
            sr2_o <= '0;
            ir_o  <= '0;
        end else begin
            sr1_o <= opnd_a_i;
            sr2_o <= opnd_b_i;
            ir_o  <= opcode_i;
        end
    end

    alu4_decode u_dec (
        .code_i (ir_o),
        .sel_o  (sel_w)
    );

    alu4_core #(.WIDTH(WIDTH)) u_core (
        .a_i     (sr1_o),
        .b_i     (sr2_o),
        .sel_i   (sel_w),
        .res_o   (res_w),
        .carry_o (cy_w)
    );

    assign valid_w   = |sel_w;
    assign op_busy_o = sel_w;

    // Destination stage: store result and flags only for a recognised code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dr_o    <= '0;
            carry_o <= 1'b0;
            neg_o   <= 1'b0;
            zero_o  <= 1'b0;
            pos_o   <= 1'b0;
        end else if (valid_w) begin
            dr_o    <= res_w;
            carry_o <= cy_w;
            neg_o   <= res_w[MSB];
            zero_o  <= (res_w == '0);
            pos_o   <= !res_w[MSB] && (res_w != '0);
        end
    end

    // R1: reset clears every register and flag.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (sr1_o == '0 && sr2_o == '0 && ir_o == '0 && dr_o == '0 &&
                    !carry_o && !neg_o && !zero_o && !pos_o));

    // R2: inputs land in source and instruction registers.
    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (sr1_o == $past(opnd_a_i) && sr2_o == $past(opnd_b_i) &&
                   ir_o == $past(opcode_i)));

    // R3: sum result and carry one edge after the sum is decoded.
    a_r3_add_result: assert property (@(posedge clk) disable iff (!rst_n)
        op_busy_o[SEL_ADD] |=>
            ({carry_o, dr_o} == ({1'b0, $past(sr1_o)} + {1'b0, $past(sr2_o)})));

    // R4, R5: carry is cleared after AND or complement.
    a_r5_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (op_busy_o[SEL_AND] || op_busy_o[SEL_NOT]) |=> !carry_o);

    // R5: complement uses the first operand only.
    a_r5_not_result: assert property (@(posedge clk) disable iff (!rst_n)
        op_busy_o[SEL_NOT] |=> (dr_o == ~$past(sr1_o)));

    // R6: unknown code holds result and flags.
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (op_busy_o == '0) |=> ($stable(dr_o) && $stable(carry_o) &&
                               $stable(neg_o) && $stable(zero_o) && $stable(pos_o)));

    // R7: exactly one condition flag after a valid operation.
    a_r7_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (|op_busy_o) |=> ($countones({neg_o, zero_o, pos_o}) == 1));

    // R8: indicator never has more than one bit set.
    a_r8_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(op_busy_o));

endmodule

// File: tb/alu4_datapath_tb.sv
module alu4_datapath_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] a_in = '0, b_in = '0, op_in = '0;
    logic [3:0] sr1, sr2, ir, dr;
    logic [2:0] busy;
    logic       cy, n, z, p;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    alu4_datapath u_dut (
        .clk(clk), .rst_n(rst_n), .opnd_a_i(a_in), .opnd_b_i(b_in),
        .opcode_i(op_in), .sr1_o(sr1), .sr2_o(sr2), .ir_o(ir), .dr_o(dr),
        .op_busy_o(busy), .carry_o(cy), .neg_o(n), .zero_o(z), .pos_o(p)
    );

    // Vector: {opcode, a, b, expected dr, expected carry}
    localparam logic [16:0] VEC [12] = '{
        {4'b0001, 4'h3, 4'h4, 4'h7, 1'b0},
        {4'b0001, 4'h9, 4'h8, 4'h1, 1'b1},
        {4'b0001, 4'h8, 4'h8, 4'h0, 1'b1},
        {4'b0001, 4'hF, 4'h1, 4'h0, 1'b1},
        {4'b0001, 4'h5, 4'h6, 4'hB, 1'b0},
        {4'b0101, 4'hC, 4'hA, 4'h8, 1'b0},
        {4'b0101, 4'h5, 4'hA, 4'h0, 1'b0},
        {4'b0101, 4'h7, 4'h3, 4'h3, 1'b0},
        {4'b1001, 4'h0, 4'h5, 4'hF, 1'b0},
        {4'b1001, 4'hF, 4'h0, 4'h0, 1'b0},
        {4'b1001, 4'hA, 4'hF, 4'h5, 1'b0},
        {4'b0001, 4'h0, 4'h0, 4'h0, 1'b0}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] nzp(input logic [3:0] r);
        return {r[3], r == 4'h0, (!r[3] && r != 4'h0)};
    endfunction

    function automatic logic [2:0] busy_of(input logic [3:0] op);
        case (op)
            4'b0001: return 3'b001;
            4'b0101: return 3'b010;
            4'b1001: return 3'b100;
            default: return 3'b000;
        endcase
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic issue(input logic [3:0] op, input logic [3:0] a, input logic [3:0] b);
        op_in = op; a_in = a; b_in = b;
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state, with nonzero inputs present.
        issue(4'b0001, 4'hF, 4'hF);
        step(); step();
        chk("R1 sr/ir after reset", {sr1, sr2, ir, dr}, 16'h0000);
        chk("R1 flags after reset", {12'h0, cy, n, z, p}, 16'h0000);
        chk("R8 busy after reset", {13'h0, busy}, 16'h0000);
        rst_n = 1'b1;

        // Table walk: R2 capture, R8 indicator, R3/R4/R5 results, R7 flags.
        for (int i = 0; i < 12; i++) begin
            logic [3:0] vop, va, vb, vdr;
            logic       vc;
            {vop, va, vb, vdr, vc} = VEC[i];
            issue(vop, va, vb);
            step();
            chk("R2 capture", {sr1, sr2, ir, 4'h0}, {va, vb, vop, 4'h0});
            chk("R8 indicator", {13'h0, busy}, {13'h0, busy_of(vop)});
            step();
            chk(vop == 4'b0001 ? "R3 result" : (vop == 4'b0101 ? "R4 result" : "R5 result"),
                {11'h0, vc, dr}, {11'h0, vc == 1'b1 ? 1'b1 : 1'b0, vdr});
            chk("R7 flags", {13'h0, n, z, p}, {13'h0, nzp(vdr)});
        end

        // R6: unknown codes after a carrying sum hold DR and all flags.
        issue(4'b0001, 4'hF, 4'h1);
        step(); step();
        chk("R3 carry set", {11'h0, cy, dr}, {11'h0, 1'b1, 4'h0});
        issue(4'b0000, 4'h7, 4'h7);
        step();
        chk("R8 unknown busy", {13'h0, busy}, 16'h0000);
        issue(4'b1111, 4'h3, 4'h9);
        step();
        chk("R6 hold dr/carry", {11'h0, cy, dr}, {11'h0, 1'b1, 4'h0});
        chk("R6 hold nzp", {13'h0, n, z, p}, {13'h0, 3'b010});
        issue(4'b0110, 4'h2, 4'h2);
        step(); step();
        chk("R6 hold after more codes", {10'h0, cy, n, z, p, 2'b00}, {10'h0, 1'b1, 3'b010, 2'b00});

        // R5: second operand ignored by complement.
        issue(4'b1001, 4'h6, 4'h0);
        step(); step();
        chk("R5 not b=0", {12'h0, dr}, 16'h0009);
        issue(4'b1001, 4'h6, 4'hF);
        step(); step();
        chk("R5 not b=F", {12'h0, dr}, 16'h0009);

        // R9: back-to-back sum then AND.
        issue(4'b0001, 4'hC, 4'h7);
        step();
        issue(4'b0101, 4'h6, 4'h3);
        step();
        chk("R9 new operands loaded", {sr1, sr2, ir, 4'h0}, {4'h6, 4'h3, 4'b0101, 4'h0});
        chk("R9 previous result", {10'h0, cy, n, z, p, dr[3:2]}, {10'h0, 1'b1, 3'b001, 2'b00});
        chk("R9 previous dr", {12'h0, dr}, 16'h0003);
        issue(4'b0000, 4'h0, 4'h0);
        step();
        chk("R9 following result", {11'h0, cy, dr}, {11'h0, 1'b0, 4'h2});
        chk("R7 following flags", {13'h0, n, z, p}, {13'h0, 3'b001});

        // R1: mid-run reset clears everything.
        issue(4'b0001, 4'h9, 4'h9);
        step(); step();
        rst_n = 1'b0;
        step();
        chk("R1 mid-run regs", {sr1, sr2, ir, dr}, 16'h0000);
        chk("R1 mid-run flags", {12'h0, cy, n, z, p}, 16'h0000);
        rst_n = 1'b1;
        step();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule